// File: doc/BRIEF.md
# Frame Buffer Control Registers with End-of-Frame Interrupt

This block is the software-visible control port of a frame buffer controller. It decodes a 32-byte register window addressed in bytes. Inside that window sit a control register, a status register and a bank of general byte registers that simply hold what software writes. The video timing logic sends it a one-cycle frame-end strobe. When the interrupt enable in the control register is set, that strobe latches an interrupt that stays raised until software clears it.

A status read returns three things in one byte: the live pending flag, a fixed monitor-sense code and a fixed colour-board flag. Driver code can identify the board and poll for the interrupt with a single access. To clear the interrupt, software writes anything to the status offset. Reads are combinational from the current address. Writes take effect at the next rising clock edge.

Top module: `fbc_regs_top`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x00, the interrupt is deasserted, the status byte reads 0x61 and every general register reads 0x00.
- R2: Offset 0x10 is the control register; it reads back the full byte last written to it.
- R3: A frame-end strobe while control bit 7 is 1 sets the pending flag at that clock edge, and `irq` reads 1 from then on.
- R4: A frame-end strobe while control bit 7 is 0 leaves the pending flag and `irq` at 0, whatever the other control bits hold.
- R5: A read of offset 0x11 returns the pending flag in bit 7, with bits 6:0 fixed at 0x61 (bits 6 and 5 are the monitor-sense code, bit 0 marks a colour board).
- R6: Any write to offset 0x11 clears the pending flag and drops `irq` at that edge, regardless of the data written.
- R7: Offsets 0x12 to 0x1F are independent byte registers that each return their last written value; writing one leaves the others unchanged.
- R8: Offsets 0x00 to 0x0F read as 0x00, and writes to them change no register.
- R9: `irq` equals the pending flag, so it stays high across further frame-end strobes until software clears it.
- R10: If a frame-end strobe with the enable set and a status write arrive in the same cycle, the pending flag ends up set.
- R11: Clearing the enable bit while an interrupt is pending does not clear the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed byte |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| frame_end | input | 1 | One-cycle end-of-frame pulse from video timing |
| irq | output | 1 | Level interrupt, high while an event is pending |

## Verification
The bench targets the cases where the interrupt logic is easy to get wrong.

- **Clear that depends on data.** A design that only clears when bit 7 is written would keep `irq` high after a write of 0x00.
- **Wrong priority on collision.** A design that lets the clear win over the set would drop an event when a frame end and a clear land together.
- **Clear tied to the enable.** A design that clears pending when the enable is turned off would drop `irq` early.
- **Missing enable gate.** A design that ignores the enable would raise `irq` with the enable off.
- **Decode errors.** A bad decode would make the low half of the window echo data, or would let one general register alias another.
- **Wrong status constants.** A design with the fixed status bits wrong would fail every status read.

// File: rtl/fbc_pkg.sv
// Shared constants for the frame buffer control register block.
package fbc_pkg;
    localparam int unsigned ADDR_W     = 5;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned WINDOW     = 1 << ADDR_W;
    localparam int unsigned CTRL_OFF   = 16;
    localparam int unsigned STAT_OFF   = 17;
    localparam int unsigned GP_FIRST   = 18;
    localparam int unsigned GP_COUNT   = WINDOW - GP_FIRST;
    localparam int unsigned GP_IDX_W   = $clog2(GP_COUNT);
    localparam int unsigned IRQ_EN_BIT = 7;
    localparam int unsigned PEND_BIT   = 7;
    localparam logic [DATA_W-1:0] STAT_FIXED = 8'h61;
endpackage

// File: rtl/fbc_addr_decode.sv
// Address decoder: maps a byte offset to at most one register target.
// Assumes the general bank occupies GP_FIRST up to the top of the window.
module fbc_addr_decode
    import fbc_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic [AW-1:0]       addr,
    output logic                sel_ctrl,
    output logic                sel_stat,
    output logic                sel_gp,
    output logic [GP_IDX_W-1:0] gp_idx
);
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_OFF);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_OFF);
    localparam logic [AW-1:0] GP_A   = AW'(GP_FIRST);

    logic [AW-1:0] gp_off;

    // Purpose: compare the offset against each region of the window.
    always_comb begin
        sel_ctrl = (addr == CTRL_A);
        sel_stat = (addr == STAT_A);
        sel_gp   = (addr >= GP_A);
        gp_off   = addr - GP_A;
        gp_idx   = gp_off[GP_IDX_W-1:0];
    end

    // R8: never more than one target selected.
    always_comb begin
        a_r8_one_target: assert ($onehot0({sel_ctrl, sel_stat, sel_gp}))
            else $error("decoder selected several targets");
    end
endmodule

// File: rtl/fbc_irq_ctrl.sv
// Control register and end-of-frame interrupt state.
// The set path has priority over the status-write clear, so a frame event
// that coincides with a clear is kept. irq is the pending flag itself.
module fbc_irq_ctrl
    import fbc_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          stat_wr,
    input  logic [DW-1:0] wdata,
    input  logic          frame_end,
    output logic [DW-1:0] ctrl_q,
    output logic          pending
);
    logic set_evt;

    // Purpose: qualify the frame strobe with the interrupt enable.
    always_comb set_evt = frame_end && ctrl_q[IRQ_EN_BIT];

    // Purpose: hold the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wdata;
    end

    // Purpose: set-dominant pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (set_evt) pending <= 1'b1;
        else if (stat_wr) pending <= 1'b0;
    end

    // R3: an enabled frame end leaves the flag set.
    a_r3_set_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && ctrl_q[IRQ_EN_BIT]) |=> pending);
    // R6: a status write without a new event clears the flag.
    a_r6_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !(frame_end && ctrl_q[IRQ_EN_BIT])) |=> !pending);
    // R4: no enabled event means the flag cannot rise.
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !(frame_end && ctrl_q[IRQ_EN_BIT])) |=> !pending);
    // R11: only a status write drops the flag.
    a_r11_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !stat_wr) |=> pending);
endmodule

// File: rtl/fbc_gp_bank.sv
// Bank of general byte registers with an indexed write and read.
// Assumes idx values at or beyond COUNT are never selected for writes.
module fbc_gp_bank
    import fbc_pkg::*;
#(
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned COUNT = GP_COUNT,
    parameter int unsigned IW    = GP_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [COUNT];

    for (genvar g = 0; g < COUNT; g++) begin : g_reg
        logic hit;
        // Purpose: decode the write to this entry.
        always_comb hit = wr && (idx == IW'(g));
        // Purpose: store one general byte.
        always_ff @(posedge clk) begin
            if (!rst_n)   regs[g] <= '0;
            else if (hit) regs[g] <= wdata;
        end
        // R7: an entry not written keeps its value.
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr && idx == IW'(g)) |=> $stable(regs[g]));
    end

    // Purpose: return the indexed entry, zero for unused indices.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < COUNT; i++)
            if (idx == IW'(i)) rdata = regs[i];
    end
endmodule

// File: rtl/fbc_regs_top.sv
// Top of the frame buffer control register block: decode, interrupt
// state, general bank and read-data merge. Reads are combinational.
module fbc_regs_top
    import fbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              frame_end,
    output logic              irq
);
    logic                sel_ctrl, sel_stat, sel_gp;
    logic [GP_IDX_W-1:0] gp_idx;
    logic [DATA_W-1:0]   ctrl_q, gp_rdata, stat_byte;
    logic                pending;

    fbc_addr_decode #(.AW(ADDR_W)) u_dec (
        .addr(bus_addr), .sel_ctrl(sel_ctrl), .sel_stat(sel_stat),
        .sel_gp(sel_gp), .gp_idx(gp_idx)
    );

    fbc_irq_ctrl #(.DW(DATA_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(bus_wr && sel_ctrl), .stat_wr(bus_wr && sel_stat),
        .wdata(bus_wdata), .frame_end(frame_end),
        .ctrl_q(ctrl_q), .pending(pending)
    );

    fbc_gp_bank #(.DW(DATA_W), .COUNT(GP_COUNT), .IW(GP_IDX_W)) u_gp (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr && sel_gp),
        .idx(gp_idx), .wdata(bus_wdata), .rdata(gp_rdata)
    );

    // Purpose: merge live pending with the fixed identification bits.
    always_comb begin
        stat_byte = STAT_FIXED;
        stat_byte[PEND_BIT] = pending;
    end

    // Purpose: select read data; unmapped offsets return zero.
    always_comb begin
        if (sel_ctrl)      bus_rdata = ctrl_q;
        else if (sel_stat) bus_rdata = stat_byte;
        else if (sel_gp)   bus_rdata = gp_rdata;
        else               bus_rdata = '0;
    end

    // Purpose: the interrupt line is the pending flag.
    always_comb irq = pending;

    // R5: a status read shows the fixed bits and the interrupt state.
    a_r5_status_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(STAT_OFF)) |->
        (bus_rdata[6:0] == STAT_FIXED[6:0] && bus_rdata[7] == irq));
    // R8: the low half of the window reads zero.
    a_r8_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < ADDR_W'(CTRL_OFF)) |-> (bus_rdata == '0));
    // R9: irq stays up through further frame ends until a status write.
    a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_wr && bus_addr == ADDR_W'(STAT_OFF))) |=> irq);
endmodule

// File: tb/fbc_regs_top_tb.sv
module fbc_regs_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       frame_end = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fbc_regs_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_end(frame_end), .irq(irq)
    );

    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_FE = 2'd2;
    // {op, addr, data, expected read, expected irq, requirement number}
    localparam int NV = 24;
    localparam logic [27:0] VEC [NV] = '{
        {OP_RD, 5'h10, 8'h00, 8'h00, 1'b0, 4'd1},  // R1 control cleared
        {OP_RD, 5'h11, 8'h00, 8'h61, 1'b0, 4'd1},  // R1 status idle
        {OP_WR, 5'h10, 8'h80, 8'h00, 1'b0, 4'd2},  // R2 enable
        {OP_RD, 5'h10, 8'h00, 8'h80, 1'b0, 4'd2},  // R2 readback
        {OP_FE, 5'h00, 8'h00, 8'h00, 1'b1, 4'd3},  // R3 event sets
        {OP_RD, 5'h11, 8'h00, 8'hE1, 1'b1, 4'd5},  // R5 pending visible
        {OP_FE, 5'h00, 8'h00, 8'h00, 1'b1, 4'd9},  // R9 stays high
        {OP_WR, 5'h11, 8'h00, 8'h00, 1'b0, 4'd6},  // R6 clear with 0x00
        {OP_RD, 5'h11, 8'h00, 8'h61, 1'b0, 4'd6},  // R6 status after clear
        {OP_FE, 5'h00, 8'h00, 8'h00, 1'b1, 4'd3},  // R3 again
        {OP_WR, 5'h11, 8'hFF, 8'h00, 1'b0, 4'd6},  // R6 clear with 0xFF
        {OP_WR, 5'h10, 8'h00, 8'h00, 1'b0, 4'd4},  // R4 disable
        {OP_FE, 5'h00, 8'h00, 8'h00, 1'b0, 4'd4},  // R4 masked event
        {OP_RD, 5'h11, 8'h00, 8'h61, 1'b0, 4'd4},  // R4 nothing pending
        {OP_WR, 5'h12, 8'h5A, 8'h00, 1'b0, 4'd7},  // R7 first entry
        {OP_WR, 5'h1F, 8'hC3, 8'h00, 1'b0, 4'd7},  // R7 last entry
        {OP_RD, 5'h12, 8'h00, 8'h5A, 1'b0, 4'd7},
        {OP_RD, 5'h1F, 8'h00, 8'hC3, 1'b0, 4'd7},
        {OP_WR, 5'h05, 8'h77, 8'h00, 1'b0, 4'd8},  // R8 unmapped write
        {OP_RD, 5'h05, 8'h00, 8'h00, 1'b0, 4'd8},  // R8 reads zero
        {OP_RD, 5'h1E, 8'h00, 8'h00, 1'b0, 4'd7},  // R7 neighbour untouched
        {OP_WR, 5'h10, 8'h3C, 8'h00, 1'b0, 4'd2},  // R2 other bits
        {OP_RD, 5'h10, 8'h00, 8'h3C, 1'b0, 4'd2},
        {OP_FE, 5'h00, 8'h00, 8'h00, 1'b0, 4'd4}   // R4 bit7 clear, others set
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus; read data sampled before the edge, irq after.
    task automatic step(input logic [1:0] op, input logic [4:0] a,
                        input logic [7:0] d, input logic [7:0] exp_rd,
                        input logic exp_irq, input string req);
        @(negedge clk);
        bus_wr    = (op == OP_WR);
        bus_addr  = a;
        bus_wdata = d;
        frame_end = (op == OP_FE);
        #1;
        if (op == OP_RD) check(req, "rdata", bus_rdata, exp_rd);
        @(posedge clk);
        #1;
        check(req, "irq", {7'd0, irq}, {7'd0, exp_irq});
    endtask

    task automatic both(input logic [4:0] a, input logic [7:0] d,
                        input logic exp_irq, input string req);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; frame_end = 1'b1;
        @(posedge clk);
        #1;
        check(req, "irq", {7'd0, irq}, {7'd0, exp_irq});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            step(VEC[i][27:26], VEC[i][25:21], VEC[i][20:13], VEC[i][12:5],
                 VEC[i][4], $sformatf("R%0d", VEC[i][3:0]));

        // R10: strobe and clear together while idle, then while pending.
        step(OP_WR, 5'h10, 8'h80, 8'h00, 1'b0, "R10");
        both(5'h11, 8'h00, 1'b1, "R10");
        both(5'h11, 8'h80, 1'b1, "R10");
        step(OP_RD, 5'h11, 8'h00, 8'hE1, 1'b1, "R10");

        // R11: disabling does not clear a pending event.
        step(OP_WR, 5'h10, 8'h00, 8'h00, 1'b1, "R11");
        step(OP_FE, 5'h00, 8'h00, 8'h00, 1'b1, "R11");
        step(OP_RD, 5'h11, 8'h00, 8'hE1, 1'b1, "R11");
        step(OP_WR, 5'h11, 8'h00, 8'h00, 1'b0, "R11");

        // R8: a write to offset 0 changes neither control nor the bank.
        step(OP_WR, 5'h10, 8'h81, 8'h00, 1'b0, "R8");
        step(OP_WR, 5'h00, 8'hEE, 8'h00, 1'b0, "R8");
        step(OP_RD, 5'h10, 8'h00, 8'h81, 1'b0, "R8");
        step(OP_RD, 5'h12, 8'h00, 8'h5A, 1'b0, "R8");
        step(OP_RD, 5'h00, 8'h00, 8'h00, 1'b0, "R8");

        // R1: reset with state loaded clears everything.
        step(OP_FE, 5'h00, 8'h00, 8'h00, 1'b1, "R1");
        @(negedge clk);
        bus_wr = 1'b0; frame_end = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "irq after reset", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step(OP_RD, 5'h10, 8'h00, 8'h00, 1'b0, "R1");
        step(OP_RD, 5'h11, 8'h00, 8'h61, 1'b0, "R1");
        step(OP_RD, 5'h12, 8'h00, 8'h00, 1'b0, "R1");
        step(OP_RD, 5'h1F, 8'h00, 8'h00, 1'b0, "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule